// File: doc/BRIEF.md
# Memory-Mapped IDE Register Bridge

This block connects a simple memory-mapped bus slave port to the register port of an IDE device. The bus sees a 4096-byte window. Inside that window every device register occupies a 16-byte slot. The slot number (the index) is bits [11:4] of the address. Byte accesses reach the seven task-file registers and the control register. The control register appears at two indices. A write to it reaches device control, and a read from it returns the alternate status. Halfword and word accesses reach only the data port at index 0. The data port is byte-swapped on the way in and on the way out, so that a host of the opposite byte order sees data in the right order.

A small sequencer accepts one access at a time. A mapped access raises a request on the IDE side and holds it until the device acknowledges. An unmapped access never reaches the device. It completes at once with an all-ones pattern whose width matches the access size. The sequencer leaves reset through a state that drives a reset strobe to the device.

States and transitions of the sequencer:
- ST_RST drives the strobe. It is the state during reset. It moves to ST_IDLE on the first clock edge after reset is released.
- ST_IDLE waits for `bus_valid`. It moves to ST_WAIT when the access is mapped. It moves to ST_RESP when the access is unmapped.
- ST_WAIT holds `ide_req`. It moves to ST_RESP on `ide_ack`.
- ST_RESP raises `bus_ready` for one cycle. It always returns to ST_IDLE.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The index is `bus_addr[11:4]`. Address bits above bit 11 and bits [3:0] have no effect on routing.
- R2: A byte access (size code 0) at index 1 to 7 goes to the IDE register whose code is equal to the index.
- R3: A byte access at index 8 or index 22 goes to IDE register code 8. This is device control on a write and alternate status on a read.
- R4: A byte access at any other index makes no IDE request. A read of it returns 0x000000FF.
- R5: A halfword access (size code 1) or a word access (size code 2) at index 0 goes to IDE register code 0, the data port. `ide_width` carries the size code.
- R6: A halfword or word access at any nonzero index makes no IDE request. A read of it returns 0x0000FFFF for a halfword and 0xFFFFFFFF for a word. Size code 3 is reserved: it is never mapped, and a read with it returns 0xFFFFFFFF.
- R7: Data lanes, writes: a byte write sends bus bits [7:0] and clears the upper bits. A halfword write swaps its two bytes. A word write reverses its four bytes. Reads follow the same rule, from `ide_rdata` to `bus_rdata`.
- R8: A mapped access raises `ide_req` in the cycle after it is accepted. `ide_reg`, `ide_we`, `ide_width` and `ide_wdata` stay stable until `ide_ack`. `bus_ready` is high for exactly one cycle, in the cycle after the acknowledge.
- R9: An unmapped access raises `bus_ready` in the cycle after it is accepted.
- R10: `ide_reset` is high while `rst_n` is low. It stays high until the first clock edge after release, and then falls.
- R11: `ide_req` is low whenever `bus_ready` is high.
- R12: `bus_rdata` is zero when a write completes, whether the write is mapped or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_we | input | 1 | 1 for a write |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | output | 1 | One-cycle completion |
| bus_rdata | output | DATA_W | Read data, valid while bus_ready is high |
| ide_req | output | 1 | Register access request |
| ide_we | output | 1 | 1 for a write to the register |
| ide_reg | output | 4 | Register code: 0 data, 1 to 7 task file, 8 control/alternate status |
| ide_width | output | 2 | Size code of the access |
| ide_wdata | output | DATA_W | Swapped write data |
| ide_rdata | input | DATA_W | Register read data, sampled with ide_ack |
| ide_ack | input | 1 | Register access done |
| ide_reset | output | 1 | Reset strobe to the device |

## Verification
The bench drives inputs on the falling edge and samples outputs on the next falling edge.
- Unmapped accesses: `bus_ready` is expected on the first falling edge after the request is driven, because the sequencer goes from ST_IDLE straight to ST_RESP.
- Mapped accesses: the bench plays the device. It answers `ide_req` after a latency of zero to two cycles, and it expects `bus_ready` on exactly the falling edge that follows the one where it raised `ide_ack`.
- Reset strobe: checked on the falling edge where reset is released and again one edge later.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_RST,
        ST_IDLE,
        ST_WAIT,
        ST_RESP
    } brg_state_e;

    localparam logic [3:0] REG_DATA = 4'd0;
    localparam logic [3:0] REG_CTRL = 4'd8;

    typedef struct packed {
        logic       hit;
        logic [3:0] code;
    } route_t;

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4,
    parameter int TF_LAST     = 7,
    parameter int CTRL_IDX_A  = 8,
    parameter int CTRL_IDX_B  = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output route_t            route
);

    localparam int IDX_W = WIN_BITS - STRIDE_BITS;

    logic [IDX_W-1:0] idx;
    logic             is_tf;
    logic             is_ctrl;
    logic             is_data;

    assign idx     = addr[WIN_BITS-1:STRIDE_BITS];
    assign is_tf   = (idx >= IDX_W'(1)) && (idx <= IDX_W'(TF_LAST));
    assign is_ctrl = (idx == IDX_W'(CTRL_IDX_A)) || (idx == IDX_W'(CTRL_IDX_B));
    assign is_data = (idx == '0);

    always_comb begin
        route = '0;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                if (is_tf) begin
                    route.hit  = 1'b1;
                    route.code = idx[3:0];
                end else if (is_ctrl) begin
                    route.hit  = 1'b1;
                    route.code = REG_CTRL;
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (is_data) begin
                    route.hit  = 1'b1;
                    route.code = REG_DATA;
                end
            end
            default: route = '0;
        endcase
    end

endmodule

// File: rtl/ide_lane_swap.sv
module ide_lane_swap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);

    localparam int NB = DATA_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] lane;
        if (i == 0) begin : g_l0
            always_comb begin
                unique case (size)
                    2'd0:    lane = din[7:0];
                    2'd1:    lane = din[15:8];
                    2'd2:    lane = din[8*(NB-1) +: 8];
                    default: lane = 8'h00;
                endcase
            end
        end else if (i == 1) begin : g_l1
            always_comb begin
                unique case (size)
                    2'd1:    lane = din[7:0];
                    2'd2:    lane = din[8*(NB-2) +: 8];
                    default: lane = 8'h00;
                endcase
            end
        end else begin : g_ln
            always_comb begin
                unique case (size)
                    2'd2:    lane = din[8*(NB-1-i) +: 8];
                    default: lane = 8'h00;
                endcase
            end
        end
        assign dout[8*i +: 8] = lane;
    end

endmodule

// File: rtl/ide_bridge_fsm.sv
module ide_bridge_fsm
    import ide_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_valid,
    input  logic       hit,
    input  logic       ide_ack,
    output brg_state_e state,
    output logic       load_req,
    output logic       load_miss,
    output logic       cap_rd
);

    brg_state_e state_q;
    brg_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST:  state_d = ST_IDLE;
            ST_IDLE: if (bus_valid) state_d = hit ? ST_WAIT : ST_RESP;
            ST_WAIT: if (ide_ack)   state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_RST;
        endcase
    end

    always_comb begin
        load_req  = 1'b0;
        load_miss = 1'b0;
        cap_rd    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_req  = bus_valid && hit;
                load_miss = bus_valid && !hit;
            end
            ST_WAIT: cap_rd = ide_ack;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
    import ide_bridge_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4,
    parameter int CTRL_IDX_A  = 8,
    parameter int CTRL_IDX_B  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ide_req,
    output logic              ide_we,
    output logic [3:0]        ide_reg,
    output logic [1:0]        ide_width,
    output logic [DATA_W-1:0] ide_wdata,
    input  logic [DATA_W-1:0] ide_rdata,
    input  logic              ide_ack,
    output logic              ide_reset
);

    localparam logic [DATA_W-1:0] FILL_BYTE = {{(DATA_W-8){1'b0}}, 8'hFF};
    localparam logic [DATA_W-1:0] FILL_HALF = {{(DATA_W-16){1'b0}}, 16'hFFFF};
    localparam logic [DATA_W-1:0] FILL_WORD = '1;

    route_t            route;
    brg_state_e        state;
    logic              load_req;
    logic              load_miss;
    logic              cap_rd;
    logic [DATA_W-1:0] wr_swapped;
    logic [DATA_W-1:0] rd_swapped;
    logic [DATA_W-1:0] fill;

    logic              we_q;
    logic [3:0]        reg_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    ide_addr_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_BITS   (WIN_BITS),
        .STRIDE_BITS(STRIDE_BITS),
        .TF_LAST    (7),
        .CTRL_IDX_A (CTRL_IDX_A),
        .CTRL_IDX_B (CTRL_IDX_B)
    ) decode_i (
        .addr (bus_addr),
        .size (bus_size),
        .route(route)
    );

    ide_lane_swap #(.DATA_W(DATA_W)) wr_swap_i (
        .din (bus_wdata),
        .size(bus_size),
        .dout(wr_swapped)
    );

    ide_lane_swap #(.DATA_W(DATA_W)) rd_swap_i (
        .din (ide_rdata),
        .size(size_q),
        .dout(rd_swapped)
    );

    ide_bridge_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .hit      (route.hit),
        .ide_ack  (ide_ack),
        .state    (state),
        .load_req (load_req),
        .load_miss(load_miss),
        .cap_rd   (cap_rd)
    );

    always_comb begin
        unique case (acc_size_e'(bus_size))
            SZ_BYTE: fill = FILL_BYTE;
            SZ_HALF: fill = FILL_HALF;
            default: fill = FILL_WORD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            reg_q   <= '0;
            size_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load_req) begin
                we_q    <= bus_we;
                reg_q   <= route.code;
                size_q  <= bus_size;
                wdata_q <= wr_swapped;
            end
            if (load_miss) begin
                rdata_q <= bus_we ? '0 : fill;
            end
            if (cap_rd) begin
                rdata_q <= we_q ? '0 : rd_swapped;
            end
        end
    end

    assign ide_req   = (state == ST_WAIT);
    assign bus_ready = (state == ST_RESP);
    assign ide_reset = (state == ST_RST);
    assign ide_we    = we_q;
    assign ide_reg   = reg_q;
    assign ide_width = size_q;
    assign ide_wdata = wdata_q;
    assign bus_rdata = rdata_q;

endmodule

// File: rtl/ide_mmio_bridge_chk.sv
module ide_mmio_bridge_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ready,
    input logic              ide_req,
    input logic              ide_ack,
    input logic              ide_we,
    input logic [3:0]        ide_reg,
    input logic [1:0]        ide_width,
    input logic [DATA_W-1:0] ide_wdata,
    input logic              ide_reset
);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_req && !ide_ack) |=> (ide_req && $stable(ide_reg) && $stable(ide_we)
                                   && $stable(ide_width) && $stable(ide_wdata)));

    // R8
    ack_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_req && ide_ack) |=> (bus_ready && !ide_req));

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R11
    req_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ide_req && bus_ready));

    // R10
    rst_strobe_chk: assert property (@(posedge clk)
        !rst_n |=> ide_reset);

    // R10
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ide_reset |=> !ide_reset);

endmodule

bind ide_mmio_bridge ide_mmio_bridge_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_ready(bus_ready),
    .ide_req  (ide_req),
    .ide_ack  (ide_ack),
    .ide_we   (ide_we),
    .ide_reg  (ide_reg),
    .ide_width(ide_width),
    .ide_wdata(ide_wdata),
    .ide_reset(ide_reset)
);

// File: tb/ide_mmio_bridge_tb_top.sv
module ide_mmio_bridge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_size = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_ready;
    logic [DATA_W-1:0] bus_rdata;
    logic              ide_req;
    logic              ide_we;
    logic [3:0]        ide_reg;
    logic [1:0]        ide_width;
    logic [DATA_W-1:0] ide_wdata;
    logic [DATA_W-1:0] ide_rdata = '0;
    logic              ide_ack = 1'b0;
    logic              ide_reset;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_mmio_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .ide_req(ide_req),
        .ide_we(ide_we), .ide_reg(ide_reg), .ide_width(ide_width),
        .ide_wdata(ide_wdata), .ide_rdata(ide_rdata), .ide_ack(ide_ack),
        .ide_reset(ide_reset)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] swap_exp(input logic [31:0] v, input logic [1:0] sz);
        case (sz)
            2'd0:    return {24'h0, v[7:0]};
            2'd1:    return {16'h0, v[7:0], v[15:8]};
            2'd2:    return {v[7:0], v[15:8], v[23:16], v[31:24]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic reset_seq();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10: strobe held during reset, no bus or IDE activity
        check(ide_reset === 1'b1, "R10 during reset", {31'h0, ide_reset}, 32'h1);
        check(bus_ready === 1'b0 && ide_req === 1'b0, "R10 idle outputs",
              {30'h0, bus_ready, ide_req}, 32'h0);
        rst_n = 1'b1;
        check(ide_reset === 1'b1, "R10 release cycle", {31'h0, ide_reset}, 32'h1);
        @(negedge clk);
        check(ide_reset === 1'b0, "R10 after first edge", {31'h0, ide_reset}, 32'h0);
    endtask

    task automatic do_access(input logic [ADDR_W-1:0] addr, input logic [1:0] sz,
                             input logic we, input logic [31:0] wd,
                             input logic [31:0] rv, input int lat);
        int          idx;
        bit          mapped;
        logic [3:0]  code;
        logic [31:0] exp_rd;
        logic [31:0] got_rd;
        bit          seen_req;
        logic [3:0]  s_reg;
        logic        s_we;
        logic [1:0]  s_width;
        logic [31:0] s_wdata;
        bit          done;
        bit          req_at_ready;
        int          cyc;
        int          ack_cyc;
        int          rdy_cyc;
        int          lat_left;
        string       rtag;

        idx    = int'(addr[11:4]);
        mapped = 1'b0;
        code   = 4'd0;
        rtag   = "R4";
        if (sz == 2'd0) begin
            if (idx >= 1 && idx <= 7) begin mapped = 1'b1; code = 4'(idx); rtag = "R2"; end
            else if (idx == 8 || idx == 22) begin mapped = 1'b1; code = 4'd8; rtag = "R3"; end
        end else begin
            rtag = "R6";
            if ((sz == 2'd1 || sz == 2'd2) && idx == 0) begin
                mapped = 1'b1; code = 4'd0; rtag = "R5";
            end
        end
        if (we)          exp_rd = 32'h0;
        else if (mapped) exp_rd = swap_exp(rv, sz);
        else if (sz == 2'd0) exp_rd = 32'h0000_00FF;
        else if (sz == 2'd1) exp_rd = 32'h0000_FFFF;
        else             exp_rd = 32'hFFFF_FFFF;

        @(negedge clk);
        bus_valid = 1'b1; bus_addr = addr; bus_size = sz; bus_we = we; bus_wdata = wd;
        seen_req = 1'b0; done = 1'b0; req_at_ready = 1'b0;
        cyc = 0; ack_cyc = -10; rdy_cyc = -1; lat_left = lat;
        s_reg = '0; s_we = 1'b0; s_width = '0; s_wdata = '0; got_rd = '0;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
            ide_ack = 1'b0;
            if (bus_ready) begin
                done = 1'b1; rdy_cyc = cyc; got_rd = bus_rdata; req_at_ready = ide_req;
            end else if (ide_req) begin
                if (!seen_req) begin
                    seen_req = 1'b1; s_reg = ide_reg; s_we = ide_we;
                    s_width = ide_width; s_wdata = ide_wdata;
                end
                if (lat_left == 0) begin
                    ide_ack = 1'b1; ide_rdata = rv; ack_cyc = cyc;
                end else begin
                    lat_left--;
                end
            end
        end
        bus_valid = 1'b0; ide_ack = 1'b0;

        // R1: routing hit depends only on address bits [11:4]
        check(seen_req == mapped, "R1 request presence", {31'h0, seen_req}, {31'h0, mapped});
        // R11
        check(req_at_ready === 1'b0, "R11 req low at ready", {31'h0, req_at_ready}, 32'h0);
        if (mapped) begin
            // R8: ready one cycle after acknowledge
            check(rdy_cyc == ack_cyc + 1, "R8 ready timing", rdy_cyc, ack_cyc + 1);
            check(s_reg == code && s_we == we, rtag, {27'h0, s_we, s_reg}, {27'h0, we, code});
            check(s_width == sz, "R5 width", {30'h0, s_width}, {30'h0, sz});
            if (we) check(s_wdata == swap_exp(wd, sz), "R7 write lanes", s_wdata, swap_exp(wd, sz));
        end else begin
            // R9: unmapped completes in the cycle after acceptance
            check(rdy_cyc == 1, "R9 ready timing", rdy_cyc, 1);
        end
        if (we)          check(got_rd == exp_rd, "R12 write rdata", got_rd, exp_rd);
        else if (mapped) check(got_rd == exp_rd, "R7 read lanes", got_rd, exp_rd);
        else             check(got_rd == exp_rd, rtag, got_rd, exp_rd);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        reset_seq();
        for (int idx = 0; idx < 256; idx++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int we = 0; we < 2; we++) begin
                    logic [ADDR_W-1:0] a;
                    a = {4'($urandom), 8'(idx), 4'($urandom)};
                    do_access(a, 2'(sz), we[0], $urandom, $urandom, (idx + sz + we) % 3);
                end
            end
        end
        // R1: aliases through upper and low address bits on fixed indices
        do_access(16'hF083, 2'd0, 1'b0, 32'h0, 32'hA5A5_5A3C, 0);
        do_access(16'h716F, 2'd0, 1'b1, 32'h0000_00E1, 32'h0, 2);
        do_access(16'h300C, 2'd2, 1'b0, 32'h0, 32'h1122_3344, 1);
        do_access(16'hC002, 2'd1, 1'b1, 32'h0000_BEEF, 32'h0, 0);
        reset_seq();
        do_access(16'h0010, 2'd0, 1'b0, 32'h0, 32'h0000_0077, 0);
        finish_run();
    end

endmodule